// File: doc/BRIEF.md
# Flash Buffered Write Sequencer

This block runs the buffered-program command of a NOR flash controller. A host issues a sequence of byte writes. First comes the buffered-write opcode, which reserves the single staging buffer. Next comes a count byte holding the number of data bytes minus one. Then come the data bytes, each at its target address, and last comes a confirm byte. When the confirm arrives, the staged bytes are programmed into the flash array. Programming uses flash semantics: a bit can only be cleared, so each stored byte is the old content ANDed with the new one.

The sequencer enforces three rules. The count must be below a power-of-two limit. The first data byte must lie in the same erase block as the opcode address. Every later data byte must fall inside the window that starts at the first data address and spans the count. A violation of any rule, or a wrong confirm value, releases the buffer, raises two error flags in the status register and sets the ready flag.

The array sits outside the block and has a synchronous read port and a write port. During a commit the block issues one read address per clock. Two cycles later it drives the matching write with the ANDed byte, and it holds `busy_o` high until the last write has been issued.

Top module: `fbw_sequencer`

## Requirements
- R1: After reset, `stat_o` = 0x80, `xstat_o` = 0x00, `xsel_o` = 0, `busy_o` = 0 and `arr_we` = 0.
- R2: Opcode 0xE8 written in idle with the buffer free reserves the buffer and latches `cmd_addr`. On the next cycle `xstat_o` = 0x80 (bit 7 means buffer available) and `xsel_o` = 1 (extended status is the selected readable register).
- R3: In idle, any byte other than 0xE8 changes nothing: status, extended status and `xsel_o` keep their values and no array write occurs.
- R4: A count byte below 2^CNT_LOG2 (32 by default, so 31 is the largest) is accepted. `xsel_o` drops to 0, `stat_o` bit 7 (ready) clears, and count+1 data bytes are expected.
- R5: A count byte of 2^CNT_LOG2 or more sets `stat_o` bits 7, 5 and 4, clears `xsel_o`, returns to idle and frees the buffer.
- R6: The first data byte must have the same address bits above the low BLK_W bits (the erase block, 64 bytes by default) as the opcode address. Its address becomes the buffer base. A mismatch sets bits 7, 5 and 4 and returns to idle.
- R7: Each later data address must lie in [base, base+count]. An address below or above this range sets bits 7, 5 and 4 and returns to idle.
- R8: A data byte is stored at offset (address − base). A repeated address keeps its last value, and offsets never written program as 0xFF.
- R9: Confirm byte 0xD0 raises `busy_o` on the next cycle. Count+1 array writes then follow, one per clock at base, base+1, … in increasing order. Afterwards `busy_o` falls and `stat_o` bit 7 is set.
- R10: Each array write stores the array's old byte ANDed with the buffered byte.
- R11: A confirm byte other than 0xD0 sets bits 7, 5 and 4, produces no array write and frees the buffer.
- R12: Opcode 0xE8 during a commit gives `xstat_o` = 0x00 and `xsel_o` = 1 and leaves the commit intact. Once the commit ends, the buffer is free again.
- R13: Status bits 5 and 4 are never cleared by the sequencer; only reset clears them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Host write strobe |
| cmd_addr | input | ADDR_W | Host write byte address |
| cmd_data | input | 8 | Host write byte (opcode, count, data or confirm) |
| stat_o | output | 8 | Status: bit 7 ready, bits 5 and 4 sequence error |
| xstat_o | output | 8 | Extended status: bit 7 buffer available |
| xsel_o | output | 1 | 1 when extended status is the register to read |
| busy_o | output | 1 | High while the buffer is being committed |
| arr_raddr | output | ADDR_W | Array read address (synchronous read) |
| arr_rdata | input | 8 | Array read data, one cycle after the address |
| arr_we | output | 1 | Array write enable |
| arr_waddr | output | ADDR_W | Array write address |
| arr_wdata | output | 8 | Array write data (old AND new) |

## Verification
The bench attacks the address rules at their edges. It tests a first byte in the next erase block, a later byte just below the base, and one just past base+count. It also tests a later byte that crosses into the next erase block but stays inside the window, which must be accepted. A design that used the wrong anchor or an off-by-one bound would either raise a false error or program stray bytes.

On the count, the bench sends 31 and 32: the first must fill all 32 buffer slots and the second must fail. It repeats an address inside one buffer and leaves one offset unwritten. A buffer that failed to overwrite, or that failed to treat empty slots as 0xFF, would corrupt the scoreboard's AND-merged values.

Finally, the bench sends an opcode during a commit, a bad confirm, and a successful sequence after an error. This exposes a buffer that is never released, a commit disturbed by host writes, and error flags that vanish.

// File: rtl/fbw_pkg.sv
package fbw_pkg;

  typedef enum logic [2:0] {
    S_IDLE,
    S_COUNT,
    S_DATA,
    S_CONFIRM,
    S_COMMIT
  } seq_state_t;

  localparam logic [7:0] OP_BUF_WRITE = 8'hE8;
  localparam logic [7:0] OP_CONFIRM   = 8'hD0;

  // status register bit positions
  localparam int ST_READY = 7;
  localparam int ST_ERR_A = 5;
  localparam int ST_ERR_B = 4;
  localparam logic [7:0] ST_FAULT_SET = 8'hB0;  // ready plus both error flags

  // extended status
  localparam logic [7:0] XST_AVAIL = 8'h80;

endpackage

// File: rtl/fbw_stage_mem.sv
// Staging buffer: one write port, one registered read port. Slots never
// written since the last clear read back as all ones.
module fbw_stage_mem #(
  parameter int DEPTH_LOG2 = 5,
  parameter int DW         = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  clr,
  input  logic                  we,
  input  logic [DEPTH_LOG2-1:0] waddr,
  input  logic [DW-1:0]         wdata,
  input  logic [DEPTH_LOG2-1:0] raddr,
  output logic [DW-1:0]         rdata
);
  localparam int DEPTH = 1 << DEPTH_LOG2;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] filled_q;
  logic [DW-1:0]    rd_q;
  logic             rd_filled_q;

  // data array kept free of reset so it maps to block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rd_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      filled_q    <= '0;
      rd_filled_q <= 1'b0;
    end else begin
      if (we) filled_q[waddr] <= 1'b1;
      rd_filled_q <= filled_q[raddr];
    end
  end

  assign rdata = rd_filled_q ? rd_q : {DW{1'b1}};

endmodule

// File: rtl/fbw_addr_window.sv
// Address rule for one data cycle: erase-block match on the first byte,
// window [base, base+last_off] on the rest.
module fbw_addr_window #(
  parameter int ADDR_W = 8,
  parameter int BLK_W  = 6,
  parameter int CNT_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  last_off,
  input  logic              first,
  output logic              ok,
  output logic [CNT_W-1:0]  off
);
  logic              same_blk;
  logic [ADDR_W-1:0] diff;
  logic              in_win;

  generate
    if (BLK_W >= ADDR_W) begin : g_one_block
      assign same_blk = 1'b1;
    end else begin : g_blocks
      assign same_blk = (addr[ADDR_W-1:BLK_W] == base[ADDR_W-1:BLK_W]);
    end
  endgenerate

  always_comb begin
    diff   = addr - base;
    in_win = (addr >= base) && (diff <= ADDR_W'(last_off));
    ok     = first ? same_blk : in_win;
    off    = first ? '0 : diff[CNT_W-1:0];
  end

endmodule

// File: rtl/fbw_commit.sv
// Commit pipeline: issue array read, merge with staged byte, drive write.
// One byte per clock; the write for index k appears two cycles after its read.
module fbw_commit #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] base,
  input  logic [CNT_W-1:0]  last_off,
  output logic [CNT_W-1:0]  buf_raddr,
  input  logic [7:0]        buf_rdata,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata,
  output logic              done
);
  logic              rd_vld_q, rd_last_q;
  logic [CNT_W-1:0]  idx_q;
  logic              mg_vld_q, mg_last_q;
  logic [ADDR_W-1:0] mg_addr_q;

  assign buf_raddr = idx_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_vld_q  <= 1'b0;
      rd_last_q <= 1'b0;
      idx_q     <= '0;
      arr_raddr <= '0;
      mg_vld_q  <= 1'b0;
      mg_last_q <= 1'b0;
      mg_addr_q <= '0;
      arr_we    <= 1'b0;
      arr_waddr <= '0;
      arr_wdata <= '0;
      done      <= 1'b0;
    end else begin
      // stage 2: merge and drive write
      arr_we    <= mg_vld_q;
      arr_waddr <= mg_addr_q;
      arr_wdata <= arr_rdata & buf_rdata;
      done      <= mg_vld_q && mg_last_q;
      // stage 1: data in flight from both memories
      mg_vld_q  <= rd_vld_q;
      mg_last_q <= rd_last_q;
      mg_addr_q <= arr_raddr;
      // stage 0: read issue
      if (start) begin
        rd_vld_q  <= 1'b1;
        idx_q     <= '0;
        arr_raddr <= base;
        rd_last_q <= (last_off == '0);
      end else if (rd_vld_q) begin
        if (rd_last_q) begin
          rd_vld_q  <= 1'b0;
          rd_last_q <= 1'b0;
        end else begin
          idx_q     <= idx_q + CNT_W'(1);
          arr_raddr <= arr_raddr + ADDR_W'(1);
          rd_last_q <= ((idx_q + CNT_W'(1)) == last_off);
        end
      end
    end
  end

endmodule

// File: rtl/fbw_sequencer.sv
// Buffered-write command sequencer (top).
// CNT_LOG2 must lie in 1..8 and be below ADDR_W.
module fbw_sequencer
  import fbw_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int BLK_W    = 6,
  parameter int CNT_LOG2 = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [7:0]        cmd_data,
  output logic [7:0]        stat_o,
  output logic [7:0]        xstat_o,
  output logic              xsel_o,
  output logic              busy_o,
  output logic [ADDR_W-1:0] arr_raddr,
  input  logic [7:0]        arr_rdata,
  output logic              arr_we,
  output logic [ADDR_W-1:0] arr_waddr,
  output logic [7:0]        arr_wdata
);
  localparam int          CNT_W   = CNT_LOG2;
  localparam int unsigned CNT_LIM = 1 << CNT_LOG2;

  seq_state_t        state_q;
  logic [7:0]        stat_q, xstat_q;
  logic              xsel_q, busy_q, used_q, first_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  last_q, rem_q;

  logic              win_ok;
  logic [CNT_W-1:0]  win_off;
  logic              count_ok, stage_we, stage_clr, commit_go, commit_done;
  logic [CNT_W-1:0]  stage_raddr;
  logic [7:0]        stage_rdata;

  assign count_ok  = (32'(cmd_data) < CNT_LIM);
  assign stage_we  = (state_q == S_DATA) && cmd_we && win_ok;
  assign stage_clr = (state_q == S_IDLE) && cmd_we && (cmd_data == OP_BUF_WRITE) && !used_q;
  assign commit_go = (state_q == S_CONFIRM) && cmd_we && (cmd_data == OP_CONFIRM);

  fbw_addr_window #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .CNT_W(CNT_W)) u_win (
    .addr     (cmd_addr),
    .base     (base_q),
    .last_off (last_q),
    .first    (first_q),
    .ok       (win_ok),
    .off      (win_off)
  );

  fbw_stage_mem #(.DEPTH_LOG2(CNT_LOG2), .DW(8)) u_stage (
    .clk   (clk),
    .rst   (rst),
    .clr   (stage_clr),
    .we    (stage_we),
    .waddr (win_off),
    .wdata (cmd_data),
    .raddr (stage_raddr),
    .rdata (stage_rdata)
  );

  fbw_commit #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_commit (
    .clk       (clk),
    .rst       (rst),
    .start     (commit_go),
    .base      (base_q),
    .last_off  (last_q),
    .buf_raddr (stage_raddr),
    .buf_rdata (stage_rdata),
    .arr_raddr (arr_raddr),
    .arr_rdata (arr_rdata),
    .arr_we    (arr_we),
    .arr_waddr (arr_waddr),
    .arr_wdata (arr_wdata),
    .done      (commit_done)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= S_IDLE;
      stat_q  <= 8'h80;
      xstat_q <= 8'h00;
      xsel_q  <= 1'b0;
      busy_q  <= 1'b0;
      used_q  <= 1'b0;
      first_q <= 1'b0;
      base_q  <= '0;
      last_q  <= '0;
      rem_q   <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (cmd_we && cmd_data == OP_BUF_WRITE) begin
            xsel_q <= 1'b1;
            if (!used_q) begin
              used_q  <= 1'b1;
              base_q  <= cmd_addr;
              xstat_q <= XST_AVAIL;
              state_q <= S_COUNT;
            end else begin
              xstat_q <= 8'h00;
            end
          end
        end
        S_COUNT: begin
          if (cmd_we) begin
            xsel_q <= 1'b0;
            if (count_ok) begin
              last_q           <= cmd_data[CNT_W-1:0];
              rem_q            <= cmd_data[CNT_W-1:0];
              first_q          <= 1'b1;
              stat_q[ST_READY] <= 1'b0;
              state_q          <= S_DATA;
            end else begin
              used_q  <= 1'b0;
              stat_q  <= stat_q | ST_FAULT_SET;
              state_q <= S_IDLE;
            end
          end
        end
        S_DATA: begin
          if (cmd_we) begin
            if (win_ok) begin
              first_q <= 1'b0;
              if (first_q) base_q <= cmd_addr;
              if (rem_q == '0) state_q <= S_CONFIRM;
              else             rem_q   <= rem_q - CNT_W'(1);
            end else begin
              first_q <= 1'b0;
              used_q  <= 1'b0;
              stat_q  <= stat_q | ST_FAULT_SET;
              state_q <= S_IDLE;
            end
          end
        end
        S_CONFIRM: begin
          if (cmd_we) begin
            if (cmd_data == OP_CONFIRM) begin
              busy_q  <= 1'b1;
              state_q <= S_COMMIT;
            end else begin
              used_q  <= 1'b0;
              stat_q  <= stat_q | ST_FAULT_SET;
              state_q <= S_IDLE;
            end
          end
        end
        S_COMMIT: begin
          if (cmd_we && cmd_data == OP_BUF_WRITE) begin
            xstat_q <= 8'h00;
            xsel_q  <= 1'b1;
          end
          if (commit_done) begin
            busy_q           <= 1'b0;
            used_q           <= 1'b0;
            stat_q[ST_READY] <= 1'b1;
            state_q          <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign stat_o  = stat_q;
  assign xstat_o = xstat_q;
  assign xsel_o  = xsel_q;
  assign busy_o  = busy_q;

endmodule

// File: rtl/fbw_checker.sv
module fbw_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_we,
  input logic [7:0]        cmd_data,
  input logic [7:0]        stat_o,
  input logic              busy_o,
  input logic [7:0]        arr_rdata,
  input logic              arr_we,
  input logic [ADDR_W-1:0] arr_waddr,
  input logic [7:0]        arr_wdata
);

  assert_write_in_commit_R9: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy_o);

  assert_busy_not_ready_R9: assert property (@(posedge clk) disable iff (rst)
    busy_o |-> !stat_o[7]);

  assert_busy_after_confirm_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(busy_o) |-> $past(cmd_we && cmd_data == 8'hD0));

  assert_ascending_writes_R9: assert property (@(posedge clk) disable iff (rst)
    (arr_we && $past(arr_we)) |-> (arr_waddr == $past(arr_waddr) + ADDR_W'(1)));

  assert_only_clears_bits_R10: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> ((arr_wdata & ~$past(arr_rdata)) == 8'h00));

  assert_err_a_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    $past(stat_o[5]) |-> stat_o[5]);

  assert_err_b_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    $past(stat_o[4]) |-> stat_o[4]);

endmodule

bind fbw_sequencer fbw_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_we    (cmd_we),
  .cmd_data  (cmd_data),
  .stat_o    (stat_o),
  .busy_o    (busy_o),
  .arr_rdata (arr_rdata),
  .arr_we    (arr_we),
  .arr_waddr (arr_waddr),
  .arr_wdata (arr_wdata)
);

// File: tb/sim_fbw_sequencer.sv
`timescale 1ns/1ps
module sim_fbw_sequencer;
  localparam int AW = 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cmd_we = 1'b0;
  logic [AW-1:0] cmd_addr = '0;
  logic [7:0]    cmd_data = '0;
  logic [7:0]    stat_o, xstat_o;
  logic          xsel_o, busy_o;
  logic [AW-1:0] arr_raddr, arr_waddr;
  logic [7:0]    arr_rdata = 8'h00;
  logic          arr_we;
  logic [7:0]    arr_wdata;

  always #5 clk = ~clk;

  fbw_sequencer #(.ADDR_W(AW), .BLK_W(6), .CNT_LOG2(5)) u0 (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_addr(cmd_addr), .cmd_data(cmd_data),
    .stat_o(stat_o), .xstat_o(xstat_o), .xsel_o(xsel_o), .busy_o(busy_o),
    .arr_raddr(arr_raddr), .arr_rdata(arr_rdata), .arr_we(arr_we),
    .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
  );

  // array model with synchronous read
  logic [7:0] arr_mem [256];
  logic [7:0] ref_mem [256];
  always @(posedge clk) begin
    arr_rdata <= arr_mem[arr_raddr];
    if (arr_we) arr_mem[arr_waddr] <= arr_wdata;
  end

  int checks = 0;
  int errors = 0;
  int seen_wr = 0;
  bit finished = 0;

  typedef struct packed { logic [7:0] a; logic [7:0] d; } wr_t;
  wr_t exp_q[$];

  logic [7:0] tb_buf [32];
  bit         tb_msk [32];
  logic [7:0] tb_base;
  bit         tb_first;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor: pops expected writes as the design issues them
  always @(negedge clk) begin
    if (!rst && arr_we && !finished) begin
      seen_wr++;
      if (exp_q.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R9 unexpected write actual=%0h expected=none", arr_waddr);
      end else begin
        wr_t e;
        e = exp_q.pop_front();
        check("R9 write address", arr_waddr, e.a);
        check("R10 write data", arr_wdata, e.d);
      end
    end
  end

  task automatic cmd(input logic [7:0] a, input logic [7:0] d);
    cmd_addr = a;
    cmd_data = d;
    cmd_we   = 1'b1;
    @(negedge clk);
    cmd_we   = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    cmd_we = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic start_buf(input logic [7:0] a);
    tb_base = a;
    for (int k = 0; k < 32; k++) tb_msk[k] = 1'b0;
    cmd(a, 8'hE8);
  endtask

  task automatic count(input logic [7:0] n);
    tb_first = 1'b1;
    cmd(8'h00, n);
  endtask

  task automatic data(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] off;
    if (tb_first) tb_base = a;
    tb_first = 1'b0;
    off = a - tb_base;
    if (off < 32) begin
      tb_buf[off[4:0]] = d;
      tb_msk[off[4:0]] = 1'b1;
    end
    cmd(a, d);
  endtask

  task automatic expect_commit(input int n);
    for (int k = 0; k <= n; k++) begin
      wr_t e;
      logic [7:0] b;
      e.a = tb_base + 8'(k);
      b   = tb_msk[k] ? tb_buf[k] : 8'hFF;
      e.d = ref_mem[e.a] & b;
      ref_mem[e.a] = e.d;
      exp_q.push_back(e);
    end
  endtask

  task automatic wait_idle();
    int t = 0;
    while (busy_o && t < 200) begin
      @(negedge clk);
      t++;
    end
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    int w0;
    for (int i = 0; i < 256; i++) begin
      arr_mem[i] = 8'(i * 53 + 17);
      ref_mem[i] = 8'(i * 53 + 17);
    end
    @(negedge clk);
    do_reset();

    // R1 reset state
    check("R1 stat", stat_o, 8'h80);
    check("R1 xstat", xstat_o, 8'h00);
    check("R1 xsel", xsel_o, 1'b0);
    check("R1 busy", busy_o, 1'b0);
    check("R1 arr_we", arr_we, 1'b0);

    // R3 idle ignores other bytes
    cmd(8'h10, 8'hD0);
    cmd(8'h11, 8'h40);
    repeat (3) @(negedge clk);
    check("R3 stat", stat_o, 8'h80);
    check("R3 xsel", xsel_o, 1'b0);
    check("R3 xstat", xstat_o, 8'h00);

    // R2 reserve
    start_buf(8'h40);
    check("R2 xstat", xstat_o, 8'h80);
    check("R2 xsel", xsel_o, 1'b1);
    // R4 accept count
    count(8'd3);
    check("R4 xsel", xsel_o, 1'b0);
    check("R4 stat ready cleared", stat_o, 8'h00);
    // R8 offsets, repeat and gap
    data(8'h45, 8'hA1);
    data(8'h47, 8'hB2);
    data(8'h46, 8'hC3);
    data(8'h47, 8'h5D);
    check("R8 no error", stat_o, 8'h00);
    expect_commit(3);
    w0 = seen_wr;
    cmd(8'h00, 8'hD0);
    check("R9 busy after confirm", busy_o, 1'b1);
    // R12 opcode during commit
    cmd(8'h00, 8'hE8);
    check("R12 xstat busy", xstat_o, 8'h00);
    check("R12 xsel busy", xsel_o, 1'b1);
    wait_idle();
    @(negedge clk);
    check("R9 ready after commit", stat_o, 8'h80);
    check("R9 write count", seen_wr - w0, 4);
    check("R9 queue drained", exp_q.size(), 0);

    // R12 buffer released
    start_buf(8'h00);
    check("R12 xstat after release", xstat_o, 8'h80);
    count(8'd0);
    data(8'h3F, 8'h0F);
    expect_commit(0);
    cmd(8'h00, 8'hD0);
    wait_idle();
    @(negedge clk);
    check("R9 single byte", exp_q.size(), 0);

    // R4 boundary count 31, R10 AND over earlier bytes
    start_buf(8'hC0);
    count(8'd31);
    check("R4 count 31 accepted", stat_o, 8'h00);
    data(8'hC0, 8'h5A);
    for (int k = 31; k >= 1; k--) data(8'hC0 + 8'(k), 8'(k) ^ 8'h3C);
    expect_commit(31);
    w0 = seen_wr;
    cmd(8'h00, 8'hD0);
    wait_idle();
    @(negedge clk);
    check("R4 full buffer writes", seen_wr - w0, 32);
    start_buf(8'h44);
    count(8'd1);
    data(8'h45, 8'h0F);
    data(8'h46, 8'hF0);
    expect_commit(1);
    cmd(8'h00, 8'hD0);
    wait_idle();
    @(negedge clk);
    check("R10 queue drained", exp_q.size(), 0);

    // R11 bad confirm
    start_buf(8'h80);
    count(8'd1);
    data(8'h80, 8'h00);
    data(8'h81, 8'h00);
    cmd(8'h00, 8'hFF);
    repeat (4) @(negedge clk);
    check("R11 stat", stat_o, 8'hB0);
    check("R11 busy", busy_o, 1'b0);
    // R13 sticky through a good sequence
    start_buf(8'h90);
    check("R11 buffer freed", xstat_o, 8'h80);
    count(8'd0);
    data(8'h90, 8'h33);
    expect_commit(0);
    cmd(8'h00, 8'hD0);
    check("R13 errors kept while busy", stat_o, 8'h30);
    wait_idle();
    @(negedge clk);
    check("R13 errors kept after commit", stat_o, 8'hB0);

    // R5 count too large
    do_reset();
    start_buf(8'h00);
    cmd(8'h00, 8'd32);
    check("R5 stat", stat_o, 8'hB0);
    check("R5 xsel", xsel_o, 1'b0);
    cmd(8'h00, 8'h05);
    check("R3 ignored after error", stat_o, 8'hB0);
    start_buf(8'h00);
    check("R5 buffer freed", xstat_o, 8'h80);

    // R6 first byte in another erase block
    do_reset();
    start_buf(8'h40);
    count(8'd1);
    data(8'h80, 8'h11);
    check("R6 block mismatch", stat_o, 8'hB0);
    cmd(8'h00, 8'hD0);
    repeat (4) @(negedge clk);

    // R7 window: crossing block allowed, below base rejected
    do_reset();
    start_buf(8'h40);
    count(8'd2);
    data(8'h7F, 8'h11);
    check("R6 same block last byte", stat_o, 8'h00);
    data(8'h81, 8'h22);
    check("R7 top of window accepted", stat_o, 8'h00);
    data(8'h7E, 8'h33);
    check("R7 below base", stat_o, 8'hB0);

    // R7 above window
    do_reset();
    start_buf(8'h00);
    count(8'd1);
    data(8'h10, 8'h44);
    data(8'h12, 8'h55);
    check("R7 above window", stat_o, 8'hB0);
    repeat (4) @(negedge clk);

    check("R9 no leftover writes", exp_q.size(), 0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule